// File: doc/BRIEF.md
# Per-Thread Issue Queue Capacity Manager

This block keeps the books for a shared issue queue used by several hardware threads. It tracks how many queue entries each thread currently holds, derives a per-thread entry ceiling from a selectable sharing policy and the set of threads that are active, and decides whether a thread may take another entry. The instruction storage, selection and wakeup logic live elsewhere. The allocating stage sends allocate pulses, the issuing or completing stage sends release pulses, and both are tagged with a thread number.

Three sharing policies are available. In the open-sharing policy every thread may use the whole queue. In the split policy the queue is divided evenly among the active threads. In the capped policy each thread may use a fixed percentage of the queue, except that a thread running alone gets all of it. The ceiling is registered, so a change of policy or of the active mask takes effect one clock later. Each thread's remaining headroom, a per-thread full flag, the global free count and a global full flag are presented combinationally from registered state. An allocation that does not fit is refused and flagged.

Top module: `iq_share_ctl`

## Requirements
- R1: With `policy_i` = 0 (open sharing), the per-thread ceiling equals TOTAL_ENTRIES.
- R2: With `policy_i` = 1 (split), the ceiling equals TOTAL_ENTRIES divided by the number of set bits in `active_i`, truncated; when no bit is set the divisor is NUM_THREADS.
- R3: With `policy_i` = 2 (capped), the ceiling equals TOTAL_ENTRIES * CAP_PCT / 100, truncated, except that exactly one active thread gets TOTAL_ENTRIES; code 3 behaves as code 0.
- R4: The ceiling is sampled from `policy_i` and `active_i` at a clock edge and appears on the outputs after that edge, not before.
- R5: Thread t's free count, in bits [t*CW +: CW] of `thr_free_o`, is its ceiling minus its occupancy, saturating at zero; `thr_full_o[t]` is high exactly when that count is zero.
- R6: `glb_free_o` equals TOTAL_ENTRIES minus the sum of all occupancies; `glb_full_o` is high exactly when it is zero.
- R7: An accepted allocate raises the tagged thread's occupancy by one and a release lowers it by one, both visible after the clock edge that samples them.
- R8: An allocate for a thread whose free count is zero, or while the global free count is zero, is refused: no occupancy changes and `alloc_err_o` is high for the one cycle after the sampling edge.
- R9: An allocate and a release for the same thread in the same cycle leave that thread's occupancy unchanged and are never refused.
- R10: A release for a thread with zero occupancy is ignored.
- R11: During reset all occupancies are zero, every ceiling is TOTAL_ENTRIES and `alloc_err_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_i | input | 2 | Sharing policy: 0 open, 1 split, 2 capped, 3 as 0 |
| active_i | input | NUM_THREADS | One bit per thread that is currently active |
| alloc_vld_i | input | 1 | Allocate request this cycle |
| alloc_tid_i | input | TW | Thread of the allocate request |
| rel_vld_i | input | 1 | Release this cycle |
| rel_tid_i | input | TW | Thread of the release |
| thr_free_o | output | NUM_THREADS*CW | Per-thread free counts, thread t at [t*CW +: CW] |
| thr_full_o | output | NUM_THREADS | Per-thread full flags |
| glb_free_o | output | CW | Global free entry count |
| glb_full_o | output | 1 | Global full flag |
| alloc_err_o | output | 1 | Refused allocate, one cycle after the request |

## Verification
The assertions assume that thread tags are below NUM_THREADS and that a caller never releases more entries than it took except in the deliberate zero-occupancy case, so occupancies stay within the queue size. The stimulus uses only legal thread numbers, changes policy and active mask only between requests, and drives allocations past the full points on purpose so that the refusal paths, rather than overflow, are exercised.

// File: rtl/iq_share_pkg.sv
package iq_share_pkg;

  typedef enum logic [1:0] {
    POL_OPEN  = 2'd0,
    POL_SPLIT = 2'd1,
    POL_CAP   = 2'd2,
    POL_RSVD  = 2'd3
  } share_pol_e;

  // Even division of the queue among the active threads.
  function automatic int unsigned split_ceiling(int unsigned total,
                                                int unsigned nact,
                                                int unsigned nthr);
    int unsigned div;
    div = (nact == 0) ? nthr : nact;
    return total / div;
  endfunction

  // Percentage cap, widened to the whole queue for a lone thread.
  function automatic int unsigned cap_ceiling(int unsigned total,
                                              int unsigned pct,
                                              int unsigned nact);
    if (nact == 1) return total;
    return (total * pct) / 100;
  endfunction

  // Remaining room under a ceiling, never below zero.
  function automatic int unsigned headroom(int unsigned ceil_v,
                                           int unsigned occ_v);
    return (ceil_v > occ_v) ? ceil_v - occ_v : 0;
  endfunction

endpackage

// File: rtl/iq_share_limits.sv
module iq_share_limits
  import iq_share_pkg::*;
#(
  parameter int NUM_THREADS   = 4,
  parameter int TOTAL_ENTRIES = 32,
  parameter int CAP_PCT       = 40,
  parameter int CW            = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             policy_i,
  input  logic [NUM_THREADS-1:0] active_i,
  output logic [CW-1:0]          ceil_o
);

  int unsigned nact;
  int unsigned ceil_next;
  share_pol_e  pol;

  assign pol = share_pol_e'(policy_i);

  always_comb begin
    nact = 0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      nact = nact + {31'd0, active_i[t]};
    end
  end

  always_comb begin
    unique case (pol)
      POL_SPLIT: ceil_next = split_ceiling(TOTAL_ENTRIES, nact, NUM_THREADS);
      POL_CAP:   ceil_next = cap_ceiling(TOTAL_ENTRIES, CAP_PCT, nact);
      default:   ceil_next = TOTAL_ENTRIES;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ceil_o <= CW'(TOTAL_ENTRIES);
    else        ceil_o <= CW'(ceil_next);
  end

  // R1: open sharing yields the full queue one edge later
  p_open_ceiling_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (policy_i == 2'd0) |=> (ceil_o == CW'(TOTAL_ENTRIES)));

  // R2: split ceiling never exceeds the queue size
  p_ceiling_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ceil_o <= CW'(TOTAL_ENTRIES));

endmodule

// File: rtl/iq_share_thread_ctr.sv
module iq_share_thread_ctr
  import iq_share_pkg::*;
#(
  parameter int TOTAL_ENTRIES = 32,
  parameter int CW            = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_i,
  input  logic          dec_i,
  input  logic [CW-1:0] ceil_i,
  output logic [CW-1:0] occ_o,
  output logic [CW-1:0] free_o
);

  logic dec_eff;

  assign dec_eff = dec_i && (occ_o != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_o <= '0;
    end else begin
      unique case ({inc_i, dec_i})
        2'b10:   occ_o <= occ_o + CW'(1);
        2'b01:   if (dec_eff) occ_o <= occ_o - CW'(1);
        default: occ_o <= occ_o;
      endcase
    end
  end

  assign free_o = CW'(headroom(int'(ceil_i), int'(occ_o)));

  // R7: occupancy stays within the queue
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    occ_o <= CW'(TOTAL_ENTRIES));

  // R9: paired allocate and release hold the count
  p_pair_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && dec_i) |=> $stable(occ_o));

  // R10: release at zero leaves zero
  p_release_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !inc_i && occ_o == '0) |=> (occ_o == '0));

endmodule

// File: rtl/iq_share_ctl.sv
module iq_share_ctl
  import iq_share_pkg::*;
#(
  parameter int NUM_THREADS   = 4,
  parameter int TOTAL_ENTRIES = 32,
  parameter int CAP_PCT       = 40,
  parameter int CW            = $clog2(TOTAL_ENTRIES + 1),
  parameter int TW            = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                policy_i,
  input  logic [NUM_THREADS-1:0]    active_i,
  input  logic                      alloc_vld_i,
  input  logic [TW-1:0]             alloc_tid_i,
  input  logic                      rel_vld_i,
  input  logic [TW-1:0]             rel_tid_i,
  output logic [NUM_THREADS*CW-1:0] thr_free_o,
  output logic [NUM_THREADS-1:0]    thr_full_o,
  output logic [CW-1:0]             glb_free_o,
  output logic                      glb_full_o,
  output logic                      alloc_err_o
);

  localparam int SW = CW + TW + 1;

  logic [CW-1:0] ceil_w;
  logic [CW-1:0] occ_w  [NUM_THREADS];
  logic [CW-1:0] free_w [NUM_THREADS];
  logic [NUM_THREADS-1:0] inc_w, dec_w;
  logic [SW-1:0] occ_sum;
  logic [CW-1:0] tid_free;
  logic          pair_same;
  logic          alloc_fits;
  logic          alloc_take;
  logic          alloc_refused;

  iq_share_limits #(
    .NUM_THREADS  (NUM_THREADS),
    .TOTAL_ENTRIES(TOTAL_ENTRIES),
    .CAP_PCT      (CAP_PCT),
    .CW           (CW)
  ) u_limits (
    .clk     (clk),
    .rst_n   (rst_n),
    .policy_i(policy_i),
    .active_i(active_i),
    .ceil_o  (ceil_w)
  );

  always_comb begin
    tid_free = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (alloc_tid_i == TW'(t)) tid_free = free_w[t];
    end
  end

  assign pair_same     = alloc_vld_i && rel_vld_i && (alloc_tid_i == rel_tid_i);
  assign alloc_fits    = (tid_free != '0) && (glb_free_o != '0);
  assign alloc_take    = alloc_vld_i && (pair_same || alloc_fits);
  assign alloc_refused = alloc_vld_i && !alloc_take;

  generate
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      assign inc_w[t] = alloc_take && (alloc_tid_i == TW'(t));
      assign dec_w[t] = rel_vld_i  && (rel_tid_i   == TW'(t));

      iq_share_thread_ctr #(
        .TOTAL_ENTRIES(TOTAL_ENTRIES),
        .CW           (CW)
      ) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (inc_w[t]),
        .dec_i (dec_w[t]),
        .ceil_i(ceil_w),
        .occ_o (occ_w[t]),
        .free_o(free_w[t])
      );

      assign thr_free_o[t*CW +: CW] = free_w[t];
      assign thr_full_o[t]          = (free_w[t] == '0);
    end
  endgenerate

  always_comb begin
    occ_sum = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      occ_sum = occ_sum + SW'(occ_w[t]);
    end
  end

  assign glb_free_o = CW'(SW'(TOTAL_ENTRIES) - occ_sum);
  assign glb_full_o = (glb_free_o == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alloc_err_o <= 1'b0;
    else        alloc_err_o <= alloc_refused;
  end

  // R8: allocate into a full queue is flagged next cycle
  p_full_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_full_o && alloc_vld_i && !pair_same) |=> alloc_err_o);

  // R8: a refused allocate with no release moves no counter
  p_refuse_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_refused && !rel_vld_i) |=> $stable(glb_free_o));

  // R6: global free count never exceeds the queue size
  p_glb_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    glb_free_o <= CW'(TOTAL_ENTRIES));

  // R9: a same-thread pair is never flagged
  p_pair_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pair_same |=> !alloc_err_o);

endmodule

// File: tb/iq_share_ctl_tb.sv
module iq_share_ctl_tb;

  localparam int NT    = 4;
  localparam int TOTAL = 32;
  localparam int PCT   = 40;
  localparam int CW    = 6;
  localparam int TW    = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        policy = 2'd0;
  logic [NT-1:0]     active = '0;
  logic              a_vld = 1'b0;
  logic [TW-1:0]     a_tid = '0;
  logic              r_vld = 1'b0;
  logic [TW-1:0]     r_tid = '0;
  logic [NT*CW-1:0]  thr_free;
  logic [NT-1:0]     thr_full;
  logic [CW-1:0]     glb_free;
  logic              glb_full;
  logic              alloc_err;

  int n_checks = 0;
  int n_fails  = 0;
  int m_occ [NT];
  int m_ceil;
  bit m_err;

  always #2 clk = ~clk;

  iq_share_ctl #(
    .NUM_THREADS  (NT),
    .TOTAL_ENTRIES(TOTAL),
    .CAP_PCT      (PCT)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .policy_i   (policy),
    .active_i   (active),
    .alloc_vld_i(a_vld),
    .alloc_tid_i(a_tid),
    .rel_vld_i  (r_vld),
    .rel_tid_i  (r_tid),
    .thr_free_o (thr_free),
    .thr_full_o (thr_full),
    .glb_free_o (glb_free),
    .glb_full_o (glb_full),
    .alloc_err_o(alloc_err)
  );

  function automatic int ref_ceiling(logic [1:0] p, logic [NT-1:0] act);
    int cnt = $countones(act);
    if (p == 2'd1) return (cnt == 0) ? TOTAL / NT : TOTAL / cnt;
    if (p == 2'd2) return (cnt == 1) ? TOTAL : (TOTAL * PCT) / 100;
    return TOTAL;
  endfunction

  function automatic int ref_sum();
    int s = 0;
    for (int t = 0; t < NT; t++) s += m_occ[t];
    return s;
  endfunction

  function automatic int ref_free(int t);
    return (m_ceil > m_occ[t]) ? m_ceil - m_occ[t] : 0;
  endfunction

  task automatic expect_eq(string tag, string what, int act_v, int exp_v);
    n_checks++;
    if (act_v != exp_v) begin
      n_fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act_v, exp_v);
    end
  endtask

  task automatic check_all(string tag);
    for (int t = 0; t < NT; t++) begin
      expect_eq(tag, $sformatf("thr_free[%0d]", t), int'(thr_free[t*CW +: CW]), ref_free(t));
      expect_eq(tag, $sformatf("thr_full[%0d]", t), int'(thr_full[t]), int'(ref_free(t) == 0));
    end
    expect_eq(tag, "glb_free", int'(glb_free), TOTAL - ref_sum());
    expect_eq(tag, "glb_full", int'(glb_full), int'(ref_sum() == TOTAL));
    expect_eq(tag, "alloc_err", int'(alloc_err), int'(m_err));
  endtask

  // One clock with the given request; model follows the requirements.
  task automatic cyc(bit av, int at, bit rv, int rt);
    bit same, ok;
    int tf, gf;
    same = av && rv && (at == rt);
    tf = ref_free(at);
    gf = TOTAL - ref_sum();
    ok = av && (same || (tf > 0 && gf > 0));
    m_err = av && !ok;
    if (!same) begin
      if (ok) m_occ[at]++;
      if (rv && m_occ[rt] > 0) m_occ[rt]--;
    end
    m_ceil = ref_ceiling(policy, active);
    a_vld = av; a_tid = TW'(at); r_vld = rv; r_tid = TW'(rt);
    @(posedge clk);
    @(negedge clk);
    a_vld = 1'b0; r_vld = 1'b0;
  endtask

  task automatic idle();
    cyc(1'b0, 0, 1'b0, 0);
  endtask

  task automatic set_cfg(logic [1:0] p, logic [NT-1:0] act);
    policy = p;
    active = act;
  endtask

  task automatic t_reset();
    for (int t = 0; t < NT; t++) m_occ[t] = 0;
    m_ceil = TOTAL;
    m_err  = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R11");
    rst_n = 1'b1;
    @(negedge clk);
    m_ceil = ref_ceiling(policy, active);
  endtask

  task automatic t_open();
    set_cfg(2'd0, 4'b0001);
    idle();
    for (int i = 0; i < 5; i++) cyc(1'b1, 0, 1'b0, 0);
    check_all("R1 R5 R7 alloc");
    cyc(1'b0, 0, 1'b1, 0);
    check_all("R7 release");
  endtask

  task automatic t_split();
    set_cfg(2'd1, 4'b1111);
    check_all("R4 before edge");
    idle();
    check_all("R2 four active");
    set_cfg(2'd1, 4'b0111);
    idle();
    check_all("R2 three active");
    for (int i = 0; i < 10; i++) cyc(1'b1, 1, 1'b0, 0);
    check_all("R5 thread full");
    cyc(1'b1, 1, 1'b0, 0);
    check_all("R8 thread refuse");
    idle();
    check_all("R8 error clears");
    cyc(1'b1, 1, 1'b1, 1);
    check_all("R9 pair on full thread");
    cyc(1'b1, 0, 1'b1, 1);
    check_all("R7 cross-thread pair");
    cyc(1'b1, 1, 1'b0, 0);
    check_all("R7 refill");
    set_cfg(2'd1, 4'b0000);
    idle();
    check_all("R2 none active");
  endtask

  task automatic t_cap();
    set_cfg(2'd2, 4'b0011);
    idle();
    check_all("R3 capped two active");
    set_cfg(2'd2, 4'b0010);
    idle();
    check_all("R3 capped lone thread");
    set_cfg(2'd3, 4'b0011);
    idle();
    check_all("R3 reserved code");
  endtask

  task automatic t_rel_empty();
    cyc(1'b0, 0, 1'b1, 3);
    check_all("R10 release at zero");
  endtask

  task automatic t_global();
    int need;
    set_cfg(2'd0, 4'b1111);
    idle();
    need = TOTAL - ref_sum();
    for (int i = 0; i < need; i++) cyc(1'b1, 2, 1'b0, 0);
    check_all("R6 global full");
    cyc(1'b1, 3, 1'b0, 0);
    check_all("R8 global refuse");
    cyc(1'b1, 3, 1'b1, 3);
    check_all("R9 pair at zero occupancy");
  endtask

  task automatic t_saturate();
    set_cfg(2'd1, 4'b1111);
    idle();
    check_all("R5 saturated headroom");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_open();
    t_split();
    t_cap();
    t_rel_empty();
    t_global();
    t_saturate();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule